// File: doc/BRIEF.md
# First-Word-Fall-Through FIFO Buffer

This block is a single-clock FIFO in which the oldest stored word always sits on the read-data output, flagged by a valid bit, without the reader asking for it. A reader looks at `rd_data` whenever `valid` is high. It pulses `rd_en` to acknowledge and consume that word, and the next stored word then takes its place on the following cycle. The writer presents `wr_data` with `wr_en` and watches `full`.

Storage has two parts: one lookahead output register, and an inferred register array of `DEPTH-1` slots behind it. A word written into an empty buffer goes straight to the output register. When the output register is consumed and the array holds nothing, a word written in the same cycle bypasses the array and goes directly to the output.

Top module: `fwft_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the buffer. After that edge `valid` is 0, `empty` is 1 and `full` is 0.
- R2: A word written into an empty buffer appears on `rd_data` with `valid` high in the cycle after the write edge, with no read strobe.
- R3: Words leave in exactly the order they were accepted.
- R4: When read and write are both asserted on a non-empty, non-full buffer, the word that followed the consumed one is on `rd_data` one cycle later, and the newly written word is kept behind the others.
- R5: `rd_en` asserted while `valid` is 0 is ignored. The buffer stays empty, and a later write is still delivered correctly.
- R6: `wr_en` asserted while `full` is 1 is ignored, even if a read happens in the same cycle. The word is not stored, and no stored word changes.
- R7: With exactly one stored word, a simultaneous read and write puts the new word on `rd_data` in the next cycle while `valid` stays high.
- R8: `full` is 1 exactly when the number of stored words, counting the output register, equals `DEPTH`.
- R9: While `valid` is 1 and `rd_en` is 0, `rd_data` and `valid` hold their values.
- R10: `empty` is always the inverse of `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Buffer holds DEPTH words |
| rd_en | input | 1 | Consume the word on rd_data |
| rd_data | output | DATA_W | Oldest stored word |
| valid | output | 1 | rd_data holds a stored word |
| empty | output | 1 | Inverse of valid |

## Verification
The bench runs the buffer with several input patterns. A single write into an empty buffer shows whether the word falls through with no strobe. A burst of writes followed by reads checks ordering through the array. Interleaved simultaneous reads and writes at one entry and at several entries tell the output bypass path apart from the array path. Strobes on an empty buffer and writes on a full one, the latter also combined with a read, show that refused operations leave the contents untouched. A bench queue model predicts `rd_data`, `valid`, `empty` and `full` after every edge.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

   // what the output register does at the next edge
   typedef enum logic [1:0] {
      HEAD_KEEP  = 2'd0,
      HEAD_TAKE_WR  = 2'd1,
      HEAD_TAKE_MEM = 2'd2,
      HEAD_DROP  = 2'd3
   } head_op_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fwft_store.sv
module fwft_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SLOTS  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic              none_left
);
   import fwft_pkg::*;

   localparam int unsigned PTR_W  = bits_for(SLOTS);
   localparam int unsigned USED_W = bits_for(SLOTS + 1);
   localparam bit          POW2   = (SLOTS > 1) && ((SLOTS & (SLOTS - 1)) == 0);

   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [PTR_W-1:0]  wptr_q, rptr_q, wptr_nx, rptr_nx;
   logic [USED_W-1:0] used_q;

   generate
      if (POW2) begin : g_wrap_free
         assign wptr_nx = wptr_q + 1'b1;
         assign rptr_nx = rptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr_q == PTR_W'(SLOTS - 1)) ? '0 : wptr_q + 1'b1;
         assign rptr_nx = (rptr_q == PTR_W'(SLOTS - 1)) ? '0 : rptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) slot_q[wptr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q <= '0;
         rptr_q <= '0;
         used_q <= '0;
      end else begin
         if (push) wptr_q <= wptr_nx;
         if (pop)  rptr_q <= rptr_nx;
         case ({push, pop})
            2'b10:   used_q <= used_q + 1'b1;
            2'b01:   used_q <= used_q - 1'b1;
            default: used_q <= used_q;
         endcase
      end
   end

   assign pop_data  = slot_q[rptr_q];
   assign none_left = (used_q == '0);

   // R6: the control never pushes into a full array
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
      !(push && !pop && used_q == USED_W'(SLOTS)));
   // R3: the control never pops an empty array
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
      !(pop && used_q == '0));

endmodule

// File: rtl/fwft_ctrl.sv
module fwft_ctrl #(
   parameter int unsigned DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic                head_vld,
   input  logic                mem_none,
   output fwft_pkg::head_op_e  head_op,
   output logic                push,
   output logic                pop,
   output logic                full
);
   import fwft_pkg::*;

   localparam int unsigned CNT_W = bits_for(DEPTH + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             wr_ok, rd_ok;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign wr_ok = wr_en && !full;
   assign rd_ok = rd_en && head_vld;

   always_comb begin
      head_op = HEAD_KEEP;
      if (!head_vld) begin
         if (wr_ok) head_op = HEAD_TAKE_WR;
      end else if (rd_ok) begin
         if (!mem_none)  head_op = HEAD_TAKE_MEM;
         else if (wr_ok) head_op = HEAD_TAKE_WR;
         else            head_op = HEAD_DROP;
      end
   end

   assign push = wr_ok && (head_op != HEAD_TAKE_WR);
   assign pop  = (head_op == HEAD_TAKE_MEM);

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else begin
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R8: the occupancy never passes the depth
   a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(DEPTH));
   // R8: occupancy and the output register agree
   a_r8_head_matches_count: assert property (@(posedge clk) disable iff (rst)
      head_vld == (cnt_q != '0));
   // R6: full with no read stays full
   a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
      (full && !rd_en) |=> full);
   // R7: one word, read and write together, goes to the bypass path
   a_r7_bypass_path: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == 1 && rd_en && wr_en) |-> (head_op == HEAD_TAKE_WR && !push));

endmodule

// File: rtl/fwft_head.sv
module fwft_head #(
   parameter int unsigned DATA_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  fwft_pkg::head_op_e op,
   input  logic [DATA_W-1:0]  wr_word,
   input  logic [DATA_W-1:0]  mem_word,
   output logic [DATA_W-1:0]  word,
   output logic               vld
);
   import fwft_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) vld <= 1'b0;
      else begin
         case (op)
            HEAD_TAKE_WR, HEAD_TAKE_MEM: vld <= 1'b1;
            HEAD_DROP:                   vld <= 1'b0;
            default:                     vld <= vld;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      case (op)
         HEAD_TAKE_WR:  word <= wr_word;
         HEAD_TAKE_MEM: word <= mem_word;
         default:       word <= word;
      endcase
   end

   // R9: the output holds while nothing is loaded
   a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
      (vld && op == HEAD_KEEP) |=> (vld && $stable(word)));

endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              valid,
   output logic              empty
);
   import fwft_pkg::*;

   localparam int unsigned SLOTS = DEPTH - 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fwft_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fwft_fifo: DATA_W must be at least 1");
      end
   endgenerate

   head_op_e          op;
   logic              push, pop, mem_none;
   logic [DATA_W-1:0] mem_word;

   fwft_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .head_vld(valid), .mem_none(mem_none), .head_op(op),
      .push(push), .pop(pop), .full(full)
   );

   fwft_store #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_store (
      .clk(clk), .rst(rst), .push(push), .push_data(wr_data),
      .pop(pop), .pop_data(mem_word), .none_left(mem_none)
   );

   fwft_head #(.DATA_W(DATA_W)) u_head (
      .clk(clk), .rst(rst), .op(op), .wr_word(wr_data),
      .mem_word(mem_word), .word(rd_data), .vld(valid)
   );

   assign empty = !valid;

   // R1: reset leaves the buffer empty and not full
   a_r1_reset_empty: assert property (@(posedge clk)
      rst |=> (!valid && !full && empty));
   // R2: a write into an empty buffer falls through
   a_r2_fall_through: assert property (@(posedge clk) disable iff (rst)
      (!valid && wr_en) |=> (valid && rd_data == $past(wr_data)));
   // R5: a read on an empty buffer without a write leaves it empty
   a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
      (!valid && !wr_en) |=> !valid);
   // R9: no read keeps the word on show
   a_r9_no_read_hold: assert property (@(posedge clk) disable iff (rst)
      (valid && !rd_en) |=> (valid && $stable(rd_data)));
   // R10: empty mirrors valid
   a_r10_empty_flag: assert property (@(posedge clk) empty == !valid);

endmodule

// File: tb/test_fwft_fifo.sv
module test_fwft_fifo;
   localparam int DW = 8;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst, wr_en, rd_en, full, valid, empty;
   logic [DW-1:0] wr_data, rd_data;

   int total = 0;
   int bad   = 0;
   logic [DW-1:0] model[$];

   always #5 clk = ~clk;

   fwft_fifo #(.DATA_W(DW), .DEPTH(DP)) i_fwft_fifo (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
      .rd_en(rd_en), .rd_data(rd_data), .valid(valid), .empty(empty)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock with the given inputs; model updated, all outputs compared
   task automatic step(input logic w, input logic [DW-1:0] d,
                       input logic r, input string tag);
      bit rd_ok, wr_ok;
      wr_en = w; wr_data = d; rd_en = r;
      @(posedge clk);
      rd_ok = r && model.size() > 0;
      wr_ok = w && model.size() < DP;
      if (rd_ok) void'(model.pop_front());
      if (wr_ok) model.push_back(d);
      #1;
      wr_en = 1'b0; rd_en = 1'b0;
      chk(tag, "valid", valid, model.size() > 0);
      chk(tag, "empty", empty, model.size() == 0);
      chk(tag, "full", full, model.size() == DP);
      if (model.size() > 0) chk(tag, "rd_data", rd_data, model[0]);
   endtask

   task automatic do_reset();
      rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      @(posedge clk); @(posedge clk); #1;
      rst = 1'b0;
      model.delete();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "valid after reset", valid, 1'b0);
      chk("R1", "full after reset", full, 1'b0);
      chk("R10", "empty after reset", empty, 1'b1);
   endtask

   task automatic t_first_word();
      do_reset();
      step(1'b1, 8'hA5, 1'b0, "R2");
      chk("R2", "fall-through word", rd_data, 8'hA5);
      chk("R2", "fall-through valid", valid, 1'b1);
      step(1'b0, 8'h00, 1'b1, "R2");
   endtask

   task automatic t_order();
      do_reset();
      for (int i = 0; i < DP; i++) step(1'b1, 8'h10 + 8'(i), 1'b0, "R3");
      for (int i = 0; i < DP; i++) begin
         chk("R3", "order", rd_data, 8'h10 + 8'(i));
         step(1'b0, 8'h00, 1'b1, "R3");
      end
   endtask

   task automatic t_full();
      do_reset();
      for (int i = 0; i < DP - 1; i++) begin
         step(1'b1, 8'h20 + 8'(i), 1'b0, "R8");
         chk("R8", "not full below depth", full, 1'b0);
      end
      step(1'b1, 8'h2F, 1'b0, "R8");
      chk("R8", "full at depth", full, 1'b1);
      step(1'b1, 8'hEE, 1'b0, "R6");
      step(1'b1, 8'hEF, 1'b1, "R6");
      chk("R6", "full write dropped", full, 1'b0);
      chk("R6", "head after read", rd_data, 8'h21);
      for (int i = 0; i < DP - 1; i++) step(1'b0, 8'h00, 1'b1, "R6");
      chk("R6", "drained", valid, 1'b0);
   endtask

   task automatic t_empty_read();
      do_reset();
      step(1'b0, 8'h00, 1'b1, "R5");
      step(1'b0, 8'h00, 1'b1, "R5");
      chk("R5", "stays empty", valid, 1'b0);
      step(1'b1, 8'h3C, 1'b0, "R5");
      chk("R5", "write after empty read", rd_data, 8'h3C);
      step(1'b0, 8'h00, 1'b1, "R5");
   endtask

   task automatic t_simul();
      do_reset();
      step(1'b1, 8'h41, 1'b0, "R4");
      step(1'b1, 8'h42, 1'b0, "R4");
      step(1'b1, 8'h43, 1'b0, "R4");
      for (int i = 0; i < 6; i++) begin
         logic [DW-1:0] nxt;
         nxt = model[1];
         step(1'b1, 8'h50 + 8'(i), 1'b1, "R4");
         chk("R4", "next word after read+write", rd_data, nxt);
      end
      while (model.size() > 0) step(1'b0, 8'h00, 1'b1, "R4");
   endtask

   task automatic t_bypass();
      do_reset();
      step(1'b1, 8'h61, 1'b0, "R7");
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 8'h70 + 8'(i), 1'b1, "R7");
         chk("R7", "bypass word", rd_data, 8'h70 + 8'(i));
         chk("R7", "valid kept", valid, 1'b1);
      end
      step(1'b0, 8'h00, 1'b1, "R7");
      chk("R7", "emptied", valid, 1'b0);
   endtask

   task automatic t_hold();
      do_reset();
      step(1'b1, 8'h81, 1'b0, "R9");
      step(1'b1, 8'h82, 1'b0, "R9");
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 8'hFF, 1'b0, "R9");
         chk("R9", "held word", rd_data, 8'h81);
      end
      step(1'b1, 8'h83, 1'b0, "R9");
      chk("R9", "held across write", rd_data, 8'h81);
      chk("R10", "empty low when valid", empty, 1'b0);
   endtask

   initial begin
      #2000000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_first_word();
      t_order();
      t_full();
      t_empty_read();
      t_simul();
      t_bypass();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule